// File: doc/BRIEF.md
# Timestamp Ring Buffer Write Manager

This block sits between a timestamp source and an on-chip buffer memory. While acquisition is running, every 128-bit timestamp record presented on the input is stored into a circular, byte-addressed buffer as a single wide write made of four 32-bit lanes. The lanes hold the fine count, the coarse count, the seconds count and a metadata word. Records that arrive while acquisition is stopped are dropped.

The block keeps a byte write pointer and a count of how many times that pointer has wrapped. Both are packed into one 32-bit status word, which is driven continuously and can also be fetched through a one-cycle register read port. Software uses the pointer to size its transfers. Because the pointer reads zero after every full buffer, software has to look at the wrap count to tell a full buffer from an empty one. A one-clock record-written pulse goes to downstream interrupt logic for each stored record.

Acquisition is controlled by a command strobe with two bits: bit 0 starts acquisition and bit 1 stops it.

Top module: `ts_ring_writer`

## Requirements
- R1: After reset, the status word is zero, acquisition is stopped, and neither `mem_we` nor `rec_done` is asserted.
- R2: A record accepted at a clock edge appears as one write in the next cycle. In that write, `mem_addr` is the byte pointer held before the edge, and lane k (`mem_wdata` bits 32k+31:32k) equals `rec_data` bits 32k+31:32k. Lane 0 is the fine count, lane 1 the coarse count and lane 2 the seconds count. Lane 3 is metadata (channel in bits 3:0, slope in bits 7:4 with 1 meaning rising, FIFO flags in bits 15:8) and is stored unchanged.
- R3: Each stored record advances the byte pointer by 16. The pointer is visible in bits 11:0 of the status word.
- R4: When a record fills the last 16 bytes of the 4096-byte buffer, the pointer returns to 0 and the wrap count (status bits 31:12) increases by one. After 2580 records from a start, the status reads pointer 320 and wrap count 10.
- R5: A command strobe with bit 0 set and bit 1 clear starts acquisition and clears both the pointer and the wrap count.
- R6: A command strobe with bit 1 set stops acquisition. Records presented while stopped cause no memory write and leave the status word unchanged. If bits 0 and 1 are set together, the counters are cleared and acquisition is left stopped.
- R7: A record presented in the same cycle as a command strobe is discarded.
- R8: `rec_done` is high for exactly one clock per stored record, in the same cycle as `mem_we`, and low in every other cycle.
- R9: A pulse on `rd_stb` produces `rd_valid` in the next cycle, with `rd_data` equal to the status word as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command strobe |
| cmd_bits | input | 2 | Bit 0 start, bit 1 stop |
| rec_valid | input | 1 | Record present this cycle |
| rec_data | input | 128 | Record, lane k in bits 32k+31:32k |
| rd_stb | input | 1 | Status read request |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Captured status word |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | 12 | Byte address of the record |
| mem_wdata | output | 128 | Record data for the buffer |
| rec_done | output | 1 | One pulse per stored record |
| status_word | output | 32 | {wrap count, byte pointer} |

## Verification
The embedded properties check several rules on every cycle:
- the pointer steps by exactly one record, and the wrap count moves only on the last slot;
- the counters hold whenever no record is accepted, and a start zeroes them;
- nothing is written while acquisition is stopped or a command is present;
- the record-written pulse matches the write enable;
- a read returns the pre-edge status.

Other behaviour only the bench scenarios can show. These are the byte address and lane placement of each record across an unbroken run of 2580 back-to-back records, the exact 320/10 reading at the end, and the command corner cases with stop and start set together.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

   // Acquisition state
   typedef enum logic [0:0] {
      ACQ_IDLE = 1'b0,
      ACQ_RUN  = 1'b1
   } acq_state_t;

   // Decoded command strobe
   typedef struct packed {
      logic halt;
      logic go;
   } cmd_t;

   localparam int CMD_GO_BIT   = 0;
   localparam int CMD_HALT_BIT = 1;

   function automatic cmd_t decode_cmd(input logic [1:0] bits);
      cmd_t c;
      c.go   = bits[CMD_GO_BIT];
      c.halt = bits[CMD_HALT_BIT];
      return c;
   endfunction

endpackage

// File: rtl/tsr_acq_ctrl.sv
module tsr_acq_ctrl
   import tsr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_we,
   input  logic [1:0] cmd_bits,
   input  logic       rec_valid,
   output logic       acq_on,
   output logic       clr,
   output logic       accept
);

   acq_state_t state_q, state_d;
   cmd_t       cmd;

   always_comb begin
      cmd     = decode_cmd(cmd_bits);
      state_d = state_q;
      if (cmd_we) begin
         if (cmd.halt)
            state_d = ACQ_IDLE;
         else if (cmd.go)
            state_d = ACQ_RUN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state_q <= ACQ_IDLE;
      else
         state_q <= state_d;
   end

   assign acq_on = (state_q == ACQ_RUN);
   assign clr    = cmd_we & cmd.go;
   assign accept = rec_valid & acq_on & ~cmd_we;

   // R6: a halt command always leaves the block stopped
   p_halt_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_bits[CMD_HALT_BIT]) |=> !acq_on);

   // R5: a lone go command leaves the block running
   p_go_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_bits == 2'b01) |=> acq_on);

endmodule

// File: rtl/tsr_ring_ptr.sv
module tsr_ring_ptr #(
   parameter int BUF_BYTES = 4096,
   parameter int REC_BYTES = 16,
   parameter int WRAP_W    = 20,
   localparam int PTR_W    = $clog2(BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   output logic [PTR_W-1:0]  ptr,
   output logic [WRAP_W-1:0] wrap
);

   localparam logic [PTR_W-1:0] STEP_B = PTR_W'(REC_BYTES);
   localparam logic [PTR_W-1:0] LAST_B = PTR_W'(BUF_BYTES - REC_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         ptr  <= '0;
         wrap <= '0;
      end else if (step) begin
         if (ptr == LAST_B) begin
            ptr  <= '0;
            wrap <= wrap + WRAP_W'(1);
         end else begin
            ptr <= ptr + STEP_B;
         end
      end
   end

   // R3: the pointer moves by one record per accepted record
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && ptr != LAST_B) |=>
         (ptr == $past(ptr) + STEP_B) && $stable(wrap));

   // R4: the last slot wraps the pointer and bumps the wrap count
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && ptr == LAST_B) |=>
         (ptr == '0) && (wrap == $past(wrap) + WRAP_W'(1)));

   // R5: a clear zeroes both counters
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ptr == '0) && (wrap == '0));

   // R6: no accepted record means no movement
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(ptr) && $stable(wrap));

endmodule

// File: rtl/tsr_rec_writer.sv
module tsr_rec_writer #(
   parameter int REC_BYTES = 16,
   parameter int LANE_W    = 32,
   parameter int PTR_W     = 12,
   localparam int REC_W    = REC_BYTES * 8,
   localparam int LANES    = REC_W / LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [REC_W-1:0] rec_data,
   input  logic [PTR_W-1:0] ptr,
   output logic             mem_we,
   output logic [PTR_W-1:0] mem_addr,
   output logic [REC_W-1:0] mem_wdata,
   output logic             rec_done
);

   logic [LANE_W-1:0] lane_q [LANES];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            lane_q[k] <= '0;
         else if (accept)
            lane_q[k] <= rec_data[k*LANE_W +: LANE_W];
      end
      assign mem_wdata[k*LANE_W +: LANE_W] = lane_q[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we   <= 1'b0;
         rec_done <= 1'b0;
         mem_addr <= '0;
      end else begin
         mem_we   <= accept;
         rec_done <= accept;
         if (accept)
            mem_addr <= ptr;
      end
   end

   // R8: one pulse per write, aligned with the write enable
   p_done_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rec_done == mem_we);

   // R2: the write address is the pointer held when the record arrived
   p_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> mem_we && (mem_addr == $past(ptr)));

endmodule

// File: rtl/tsr_status_port.sv
module tsr_status_port #(
   parameter int STATUS_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_stb,
   input  logic [STATUS_W-1:0] status,
   output logic                rd_valid,
   output logic [STATUS_W-1:0] rd_data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_stb;
         if (rd_stb)
            rd_data <= status;
      end
   end

   // R9: read returns the pre-edge status one cycle later
   p_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> rd_valid && (rd_data == $past(status)));

endmodule

// File: rtl/ts_ring_writer.sv
module ts_ring_writer #(
   parameter int BUF_BYTES = 4096,
   parameter int REC_BYTES = 16,
   parameter int LANE_W    = 32,
   parameter int WRAP_W    = 20,
   localparam int PTR_W    = $clog2(BUF_BYTES),
   localparam int REC_W    = REC_BYTES * 8,
   localparam int STATUS_W = WRAP_W + PTR_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_we,
   input  logic [1:0]          cmd_bits,
   input  logic                rec_valid,
   input  logic [REC_W-1:0]    rec_data,
   input  logic                rd_stb,
   output logic                rd_valid,
   output logic [STATUS_W-1:0] rd_data,
   output logic                mem_we,
   output logic [PTR_W-1:0]    mem_addr,
   output logic [REC_W-1:0]    mem_wdata,
   output logic                rec_done,
   output logic [STATUS_W-1:0] status_word
);

   initial begin
      assert ((BUF_BYTES & (BUF_BYTES - 1)) == 0)
         else $error("buffer size must be a power of two");
      assert ((REC_BYTES & (REC_BYTES - 1)) == 0 && BUF_BYTES % REC_BYTES == 0)
         else $error("record size must be a power of two dividing the buffer");
      assert (REC_W % LANE_W == 0)
         else $error("record must be whole lanes");
      assert (WRAP_W > 0)
         else $error("wrap count needs at least one bit");
   end

   logic              acq_on, clr, accept;
   logic [PTR_W-1:0]  ptr;
   logic [WRAP_W-1:0] wrap;

   tsr_acq_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_we    (cmd_we),
      .cmd_bits  (cmd_bits),
      .rec_valid (rec_valid),
      .acq_on    (acq_on),
      .clr       (clr),
      .accept    (accept)
   );

   tsr_ring_ptr #(
      .BUF_BYTES (BUF_BYTES),
      .REC_BYTES (REC_BYTES),
      .WRAP_W    (WRAP_W)
   ) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .step  (accept),
      .ptr   (ptr),
      .wrap  (wrap)
   );

   tsr_rec_writer #(
      .REC_BYTES (REC_BYTES),
      .LANE_W    (LANE_W),
      .PTR_W     (PTR_W)
   ) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .rec_data  (rec_data),
      .ptr       (ptr),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .rec_done  (rec_done)
   );

   assign status_word = {wrap, ptr};

   tsr_status_port #(
      .STATUS_W (STATUS_W)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_stb   (rd_stb),
      .status   (status_word),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   // R6: nothing is written when acquisition was stopped
   p_stop_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !acq_on |=> !mem_we);

   // R7: a record alongside a command never reaches memory
   p_cmd_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we |=> !mem_we);

   // R6: a stopped block keeps its status word still
   p_stop_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!acq_on && !cmd_we) |=> $stable(status_word));

endmodule

// File: tb/ts_ring_writer_test.sv
module ts_ring_writer_test;

   localparam int NREC = 2580;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_we = 1'b0;
   logic [1:0]   cmd_bits = 2'b00;
   logic         rec_valid = 1'b0;
   logic [127:0] rec_data = '0;
   logic         rd_stb = 1'b0;
   logic         rd_valid;
   logic [31:0]  rd_data;
   logic         mem_we;
   logic [11:0]  mem_addr;
   logic [127:0] mem_wdata;
   logic         rec_done;
   logic [31:0]  status_word;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ts_ring_writer uut (
      .clk (clk), .rst_n (rst_n), .cmd_we (cmd_we), .cmd_bits (cmd_bits),
      .rec_valid (rec_valid), .rec_data (rec_data), .rd_stb (rd_stb),
      .rd_valid (rd_valid), .rd_data (rd_data), .mem_we (mem_we),
      .mem_addr (mem_addr), .mem_wdata (mem_wdata), .rec_done (rec_done),
      .status_word (status_word)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Record i: fine, coarse, seconds, metadata (channel i%5+1, slope i%2)
   function automatic logic [127:0] mk_rec(input int i);
      logic [31:0] w0, w1, w2, w3;
      w0 = 32'(i * 7 + 3);
      w1 = 32'(i) ^ 32'hA5A5_0000;
      w2 = 32'(i / 100) | 32'h5000_0000;
      w3 = {16'h0, 4'h0, 4'(i % 3), 4'(i % 2), 4'(i % 5 + 1)};
      return {w3, w2, w1, w0};
   endfunction

   function automatic logic [31:0] exp_status(input int n);
      return {20'(n / 256), 12'((n * 16) % 4096)};
   endfunction

   task automatic send_cmd(input logic [1:0] b);
      @(negedge clk);
      cmd_we = 1'b1; cmd_bits = b;
      @(negedge clk);
      cmd_we = 1'b0; cmd_bits = 2'b00;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] snap;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(status_word == 32'd0, "R1", "status", 128'(status_word), 128'd0);
      chk(!mem_we && !rec_done, "R1", "write idle", 128'({mem_we, rec_done}), 128'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: record before any start is dropped
      rec_valid = 1'b1; rec_data = mk_rec(99);
      @(negedge clk);
      rec_valid = 1'b0;
      chk(!mem_we && !rec_done, "R6", "no write while stopped", 128'(mem_we), 128'd0);
      chk(status_word == 32'd0, "R6", "status held", 128'(status_word), 128'd0);

      // R5: start
      send_cmd(2'b01);
      chk(status_word == 32'd0, "R5", "status after start", 128'(status_word), 128'd0);

      // R2 R3 R4 R8: back-to-back sweep
      for (int i = 0; i < NREC; i++) begin
         rec_valid = 1'b1; rec_data = mk_rec(i);
         @(negedge clk);
         chk(mem_we && rec_done, "R8", "write pulse", 128'({mem_we, rec_done}), 128'd3);
         chk(mem_addr == 12'((i * 16) % 4096), "R2", "address", 128'(mem_addr),
             128'((i * 16) % 4096));
         chk(mem_wdata == mk_rec(i), "R2", "lanes", mem_wdata, mk_rec(i));
         chk(status_word == exp_status(i + 1), "R3", "pointer", 128'(status_word),
             128'(exp_status(i + 1)));
      end
      rec_valid = 1'b0;
      @(negedge clk);
      chk(!rec_done && !mem_we, "R8", "pulse ends", 128'(rec_done), 128'd0);
      chk(status_word[11:0] == 12'd320, "R4", "final pointer", 128'(status_word[11:0]), 128'd320);
      chk(status_word[31:12] == 20'd10, "R4", "final wrap", 128'(status_word[31:12]), 128'd10);

      // R9: read port
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      chk(rd_valid && rd_data == exp_status(NREC), "R9", "read", 128'(rd_data),
          128'(exp_status(NREC)));
      @(negedge clk);
      chk(!rd_valid, "R9", "read valid one cycle", 128'(rd_valid), 128'd0);

      // R6: stop, then records dropped
      send_cmd(2'b10);
      snap = status_word;
      for (int j = 0; j < 3; j++) begin
         rec_valid = 1'b1; rec_data = mk_rec(j);
         @(negedge clk);
         chk(!mem_we, "R6", "dropped after stop", 128'(mem_we), 128'd0);
         chk(status_word == snap, "R6", "status frozen", 128'(status_word), 128'(snap));
      end
      rec_valid = 1'b0;

      // R5: restart clears
      send_cmd(2'b01);
      chk(status_word == 32'd0, "R5", "cleared by start", 128'(status_word), 128'd0);

      // R7: record alongside a command is discarded
      @(negedge clk);
      rec_valid = 1'b1; rec_data = mk_rec(5); cmd_we = 1'b1; cmd_bits = 2'b01;
      @(negedge clk);
      rec_valid = 1'b0; cmd_we = 1'b0; cmd_bits = 2'b00;
      chk(!mem_we && status_word == 32'd0, "R7", "record with command", 128'(status_word), 128'd0);

      // R2 R8: single record after restart lands at 0
      rec_valid = 1'b1; rec_data = mk_rec(7);
      @(negedge clk);
      rec_valid = 1'b0;
      chk(mem_we && mem_addr == 12'd0, "R2", "restart address", 128'(mem_addr), 128'd0);
      chk(status_word == 32'd16, "R3", "one record", 128'(status_word), 128'd16);
      @(negedge clk);
      chk(!rec_done, "R8", "single pulse", 128'(rec_done), 128'd0);

      // R6: both bits clear counters and stop
      send_cmd(2'b11);
      chk(status_word == 32'd0, "R6", "both bits clear", 128'(status_word), 128'd0);
      rec_valid = 1'b1; rec_data = mk_rec(8);
      @(negedge clk);
      rec_valid = 1'b0;
      chk(!mem_we && status_word == 32'd0, "R6", "both bits stop", 128'(mem_we), 128'd0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule